// File: doc/BRIEF.md
# Prefix-Decoded SPI Command Register Interface

This block is a 16-bit serial slave that receives command words from a host controller and stores them in a bank of ten configuration registers. It does not use a fixed address field. Each register is picked out by a command code in the top bits of the word, and the codes have different lengths (3, 4, 7 or 8 bits). The bits below the code carry the data. Every register keeps the whole 16-bit word it was last given, code bits included, so each reset value is a complete command word.

A word whose top bit is 0 is a status read. During every frame the block shifts a snapshot of its 16 status flags out on SDO, MSB first. Some status bits are live levels taken from the flag inputs. The others are event bits: a one-cycle pulse sets them, and they stay set until a completed status-read frame clears them.

The serial pins are sampled by the block clock through two-stage synchronisers. A control state machine tracks the frame through four states:
- `ST_IDLE`: chip select is high.
- `ST_RECV`: chip select is low and at most 16 bits have arrived.
- `ST_OVRUN`: a 17th rising clock edge arrived.
- `ST_APPLY`: a single-cycle commit.

The transitions are:
- IDLE→RECV when chip select falls.
- RECV→APPLY when chip select rises after exactly 16 rising edges.
- RECV→IDLE when chip select rises after any other count.
- RECV→OVRUN on the 17th rising edge.
- OVRUN→IDLE when chip select rises.
- APPLY→IDLE always.

Top module: `pfx_cmd_regif`

## Requirements
- R1: After reset the ten registers hold these values:
  - 0: general 0x8008
  - 1: frequency-control 0xC4F7
  - 2: transmit 0x9800
  - 3: centre-frequency 0xA680
  - 4: receive 0x9080
  - 5: buffer/reset 0xCA80
  - 6: sync 0xCED4
  - 7: power 0x8208
  - 8: wake-timer 0xE196
  - 9: battery/clock 0xC000

  Register i appears on cfg_o[16*i+15:16*i].
- R2: A word whose bits 15:13 are 111 is stored whole in the wake-timer register. Its 13 low bits are data.
- R3: A word whose bits 15:12 are 1010 is stored whole in the centre-frequency register.
- R4: A word whose bits 15:9 are 1001100 is stored whole in the transmit register. Bit 8 is data, so top bytes 0x98 and 0x99 both reach it.
- R5: These top bytes select a register by an 8-bit code:
  - 0x80: general
  - 0x82: power
  - 0x90: receive
  - 0xC0: battery/clock
  - 0xC4: frequency-control
  - 0xCA: buffer/reset
  - 0xCE: sync
- R6: A word that matches no code changes no register, for example top byte 0x91, 0x9A, 0xB8, 0xD0 or any value below 0x80. When more than one code matches, the longest code wins.
- R7: A register is written only when chip select rises after exactly 16 SCK rising edges. Frames of 15 or 17 bits are discarded.
- R8: SDI is sampled on SCK rising edges, MSB first.
- R9: SDO is low whenever chip select is high. While chip select is low, SDO presents the status snapshot MSB first: bit 15 appears after chip select falls, and the next bit appears after each SCK falling edge.
- R10: Status bits in the event mask (default 0xE020: bits 15, 14, 13 and 5) latch on a one-cycle input pulse and hold. All other status bits follow the flag inputs directly.
- R11: A complete 16-bit frame whose bit 15 is 0 clears the event bits that were captured in its snapshot. A write frame does not clear them.
- R12: Driving rst_n_i low returns every register to its R1 value and clears all latched event bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that oversamples the serial pins |
| rst_n_i | input | 1 | Asynchronous active-low hardware reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial status data out |
| stat_i | input | 16 | Status flag inputs (event pulses and live levels) |
| cfg_o | output | 160 | Ten 16-bit configuration registers, register 0 in the low bits |

## Verification
The bench sweeps every possible top byte with a data byte derived from it. After each frame it compares all ten registers against a model built from the code table in the requirements. That sweep shows whether a short code such as 111 or 1010 steals words meant for a neighbour, and whether an unmatched code such as 0x91 or 0x9A slips into the receive or transmit register.

Frames of 15 and 17 bits are sent to expose a design that commits on the chip-select edge without checking the count. Such a design would store a shifted word.

Event flags are pulsed and then read twice, with a write frame in between. A design that clears on any frame, or never clears, returns the wrong second snapshot. A mid-run reset confirms that the defaults come back.

// File: rtl/pfx_regif_pkg.sv
package pfx_regif_pkg;

    localparam int NREG    = 10;
    localparam int FRAME_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_OVRUN,
        ST_APPLY
    } frame_st_e;

    // Power-on / hardware-reset value of each register
    function automatic logic [15:0] reg_reset(input int idx);
        case (idx)
            0:       return 16'h8008;
            1:       return 16'hC4F7;
            2:       return 16'h9800;
            3:       return 16'hA680;
            4:       return 16'h9080;
            5:       return 16'hCA80;
            6:       return 16'hCED4;
            7:       return 16'h8208;
            8:       return 16'hE196;
            9:       return 16'hC000;
            default: return 16'h0000;
        endcase
    endfunction

    // Command code left-aligned in a 16-bit word
    function automatic logic [15:0] reg_code(input int idx);
        case (idx)
            0:       return 16'h8000;
            1:       return 16'hC400;
            2:       return 16'h9800;
            3:       return 16'hA000;
            4:       return 16'h9000;
            5:       return 16'hCA00;
            6:       return 16'hCE00;
            7:       return 16'h8200;
            8:       return 16'hE000;
            9:       return 16'hC000;
            default: return 16'h0000;
        endcase
    endfunction

    // Length of the code in bits
    function automatic int reg_len(input int idx);
        case (idx)
            2:       return 7;
            3:       return 4;
            8:       return 3;
            default: return 8;
        endcase
    endfunction

    function automatic logic [15:0] code_mask(input int len);
        return 16'hFFFF << (16 - len);
    endfunction

endpackage

// File: rtl/pfx_regif_sync.sv
module pfx_regif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic sdi_o
);

    // bit 0 = sck, bit 1 = cs_n, bit 2 = sdi
    localparam logic [2:0] IDLE_LVL = 3'b010;

    logic [2:0] chain_q [STAGES];
    logic [2:0] prev_q;
    logic [2:0] raw;

    assign raw = {sdi_i, cs_n_i, sck_i};

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_n_i) begin
                    if (!rst_n_i) chain_q[s] <= IDLE_LVL;
                    else          chain_q[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_n_i) begin
                    if (!rst_n_i) chain_q[s] <= IDLE_LVL;
                    else          chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) prev_q <= IDLE_LVL;
        else          prev_q <= chain_q[STAGES-1];
    end

    assign sck_rise_o =  chain_q[STAGES-1][0] & ~prev_q[0];
    assign sck_fall_o = ~chain_q[STAGES-1][0] &  prev_q[0];
    assign cs_fall_o  = ~chain_q[STAGES-1][1] &  prev_q[1];
    assign cs_rise_o  =  chain_q[STAGES-1][1] & ~prev_q[1];
    assign sdi_o      =  chain_q[STAGES-1][2];

endmodule

// File: rtl/pfx_regif_fsm.sv
module pfx_regif_fsm
    import pfx_regif_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         sck_rise_i,
    input  logic         sck_fall_i,
    input  logic         cs_fall_i,
    input  logic         cs_rise_i,
    input  logic         sdi_i,
    input  logic [W-1:0] stat_view_i,
    output logic [W-1:0] word_o,
    output logic         apply_o,
    output logic         rd_clr_o,
    output logic [W-1:0] snap_o,
    output logic         sdo_bit_o
);

    localparam int             CW   = $clog2(W + 1);
    localparam logic [CW-1:0]  FULL = CW'(W);

    frame_st_e     state_q, state_d;
    logic [CW-1:0] bitcnt_q;
    logic [W-1:0]  rx_q;
    logic [W-1:0]  tx_q;
    logic [W-1:0]  snap_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall_i) state_d = ST_RECV;
            ST_RECV: begin
                if (cs_rise_i)
                    state_d = (bitcnt_q == FULL) ? ST_APPLY : ST_IDLE;
                else if (sck_rise_i && bitcnt_q == FULL)
                    state_d = ST_OVRUN;
            end
            ST_OVRUN: if (cs_rise_i) state_d = ST_IDLE;
            ST_APPLY: state_d = ST_IDLE;
        endcase
    end

    // datapath: receive shifter, bit counter, transmit shifter, snapshot
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            bitcnt_q <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            snap_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tx_q     <= stat_view_i;
                    bitcnt_q <= '0;
                    if (cs_fall_i) snap_q <= stat_view_i;
                end
                ST_RECV: begin
                    if (sck_rise_i && bitcnt_q != FULL) begin
                        rx_q     <= {rx_q[W-2:0], sdi_i};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    if (sck_fall_i) tx_q <= {tx_q[W-2:0], 1'b0};
                end
                ST_OVRUN: begin
                    if (sck_fall_i) tx_q <= {tx_q[W-2:0], 1'b0};
                end
                ST_APPLY: bitcnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        apply_o   = 1'b0;
        rd_clr_o  = 1'b0;
        unique case (state_q)
            ST_APPLY: begin
                apply_o  = rx_q[W-1];
                rd_clr_o = ~rx_q[W-1];
            end
            default: ;
        endcase
        word_o    = rx_q;
        snap_o    = snap_q;
        sdo_bit_o = tx_q[W-1];
    end

    // R7
    apply_full_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_APPLY) |-> (bitcnt_q == FULL));

    // R7
    apply_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_APPLY) |=> (state_q == ST_IDLE));

    // R8
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_RECV) |-> (bitcnt_q <= FULL));

endmodule

// File: rtl/pfx_regif_decode.sv
module pfx_regif_decode
    import pfx_regif_pkg::*;
(
    input  logic [FRAME_W-1:0] word_i,
    output logic [NREG-1:0]    sel_o
);

    logic [NREG-1:0] hit;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_match
            localparam logic [15:0] CODE = reg_code(g);
            localparam logic [15:0] MASK = code_mask(reg_len(g));
            assign hit[g] = ((word_i ^ CODE) & MASK) == 16'h0000;
        end
    endgenerate

    // longest matching code takes the word
    always_comb begin
        int best_len;
        sel_o    = '0;
        best_len = 0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i] && reg_len(i) > best_len) begin
                best_len = reg_len(i);
                sel_o    = '0;
                sel_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfx_regif_bank.sv
module pfx_regif_bank
    import pfx_regif_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic                    wr_en_i,
    input  logic [NREG-1:0]         sel_i,
    input  logic [FRAME_W-1:0]      word_i,
    output logic [NREG*FRAME_W-1:0] cfg_o
);

    logic [NREG-1:0][FRAME_W-1:0] regs_q;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_n_i) begin
                if (!rst_n_i)                regs_q[g] <= reg_reset(g);
                else if (wr_en_i && sel_i[g]) regs_q[g] <= word_i;
            end
            assign cfg_o[g*FRAME_W +: FRAME_W] = regs_q[g];
        end
    endgenerate

    // R6
    bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wr_en_i |=> $stable(regs_q));

    // R5
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $onehot0(sel_i));

endmodule

// File: rtl/pfx_regif_status.sv
module pfx_regif_status #(
    parameter int          W           = 16,
    parameter logic [15:0] STICKY_MASK = 16'hE020
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] stat_i,
    input  logic         clr_i,
    input  logic [W-1:0] snap_i,
    output logic [W-1:0] view_o
);

    localparam logic [W-1:0] MASK = W'(STICKY_MASK);

    logic [W-1:0] latch_q;
    logic [W-1:0] drop;

    assign drop = clr_i ? (snap_i & MASK) : '0;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) latch_q <= '0;
        else          latch_q <= (latch_q & ~drop) | (stat_i & MASK);
    end

    assign view_o = latch_q | (stat_i & ~MASK);

    // R11
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !clr_i |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

endmodule

// File: rtl/pfx_cmd_regif.sv
module pfx_cmd_regif
    import pfx_regif_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] STICKY_MASK = 16'hE020
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic                    sck_i,
    input  logic                    cs_n_i,
    input  logic                    sdi_i,
    output logic                    sdo_o,
    input  logic [FRAME_W-1:0]      stat_i,
    output logic [NREG*FRAME_W-1:0] cfg_o
);

    logic               sck_rise, sck_fall, cs_fall, cs_rise, sdi_s;
    logic [FRAME_W-1:0] word, snap, view;
    logic               apply, rd_clr, sdo_bit;
    logic [NREG-1:0]    sel;

    pfx_regif_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .sck_i      (sck_i),
        .cs_n_i     (cs_n_i),
        .sdi_i      (sdi_i),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_fall_o  (cs_fall),
        .cs_rise_o  (cs_rise),
        .sdi_o      (sdi_s)
    );

    pfx_regif_fsm #(.W(FRAME_W)) fsm_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .sck_rise_i  (sck_rise),
        .sck_fall_i  (sck_fall),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .sdi_i       (sdi_s),
        .stat_view_i (view),
        .word_o      (word),
        .apply_o     (apply),
        .rd_clr_o    (rd_clr),
        .snap_o      (snap),
        .sdo_bit_o   (sdo_bit)
    );

    pfx_regif_decode dec_i (
        .word_i (word),
        .sel_o  (sel)
    );

    pfx_regif_bank bank_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .wr_en_i (apply),
        .sel_i   (sel),
        .word_i  (word),
        .cfg_o   (cfg_o)
    );

    pfx_regif_status #(.W(FRAME_W), .STICKY_MASK(STICKY_MASK)) stat_u (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .stat_i  (stat_i),
        .clr_i   (rd_clr),
        .snap_i  (snap),
        .view_o  (view)
    );

    // output forced low while the block is not selected
    assign sdo_o = ~cs_n_i & sdo_bit;

endmodule

// File: tb/pfx_cmd_regif_tb.sv
`timescale 1ns/1ps
module pfx_cmd_regif_tb_top;

    localparam int HALF = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdi = 1'b0;
    logic         sdo;
    logic [15:0]  stat = 16'h0000;
    logic [159:0] cfg;

    int total = 0;
    int bad   = 0;
    logic [15:0] mdl [10];
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    pfx_cmd_regif dut_i (
        .clk_i   (clk),
        .rst_n_i (rst_n),
        .sck_i   (sck),
        .cs_n_i  (cs_n),
        .sdi_i   (sdi),
        .sdo_o   (sdo),
        .stat_i  (stat),
        .cfg_o   (cfg)
    );

    function automatic int target(input logic [15:0] w);
        casez (w[15:8])
            8'b111?????: return 8;
            8'b1010????: return 3;
            8'b1001100?: return 2;
            8'h80:       return 0;
            8'h82:       return 7;
            8'h90:       return 4;
            8'hC0:       return 9;
            8'hC4:       return 1;
            8'hCA:       return 5;
            8'hCE:       return 6;
            default:     return -1;
        endcase
    endfunction

    task automatic model_reset();
        mdl[0] = 16'h8008; mdl[1] = 16'hC4F7; mdl[2] = 16'h9800; mdl[3] = 16'hA680;
        mdl[4] = 16'h9080; mdl[5] = 16'hCA80; mdl[6] = 16'hCED4; mdl[7] = 16'h8208;
        mdl[8] = 16'hE196; mdl[9] = 16'hC000;
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bank(input string tag);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 10; i++)
            if (cfg[i*16 +: 16] !== mdl[i]) begin
                ok = 1'b0;
                $display("  reg %0d actual=%h expected=%h", i, cfg[i*16 +: 16], mdl[i]);
            end
        chk(ok, tag, 32'(cfg[15:0]), 32'(mdl[0]));
    endtask

    task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] got);
        got = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = n - 1; k >= 0; k--) begin
            sdi = bits[k];
            repeat (HALF) @(negedge clk);
            got = {got[30:0], sdo};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic write16(input logic [15:0] w);
        logic [31:0] g;
        int t;
        xfer({16'h0, w}, 16, g);
        t = target(w);
        if (t >= 0) mdl[t] = w;
    endtask

    task automatic pulse(input logic [15:0] ev, input logic [15:0] live);
        @(negedge clk) stat = ev | live;
        @(negedge clk) stat = live;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset values
        for (int i = 0; i < 10; i++)
            chk(cfg[i*16 +: 16] === mdl[i], "R1 reset value", 32'(cfg[i*16 +: 16]), 32'(mdl[i]));
        chk(sdo === 1'b0, "R9 sdo idle", 32'(sdo), 0);

        // R8 MSB-first capture
        write16(16'h80A1);
        chk(cfg[15:0] === 16'h80A1, "R8 bit order", 32'(cfg[15:0]), 32'h80A1);

        // R2 / R3 / R4 boundary data
        write16(16'hFFFF);
        chk(cfg[8*16 +: 16] === 16'hFFFF, "R2 wake all ones", 32'(cfg[8*16 +: 16]), 32'hFFFF);
        write16(16'hE000);
        chk(cfg[8*16 +: 16] === 16'hE000, "R2 wake zero data", 32'(cfg[8*16 +: 16]), 32'hE000);
        write16(16'hAFFF);
        chk(cfg[3*16 +: 16] === 16'hAFFF, "R3 centre freq", 32'(cfg[3*16 +: 16]), 32'hAFFF);
        write16(16'h99C3);
        chk(cfg[2*16 +: 16] === 16'h99C3, "R4 transmit bit8 data", 32'(cfg[2*16 +: 16]), 32'h99C3);

        // R6 unmatched codes
        write16(16'h91FF); chk_bank("R6 code 0x91 ignored");
        write16(16'h9ABC); chk_bank("R6 code 0x9A ignored");
        write16(16'hB812); chk_bank("R6 code 0xB8 ignored");
        write16(16'hD055); chk_bank("R6 code 0xD0 ignored");

        // R7 wrong frame lengths
        xfer({17'h0, 15'h4055}, 15, rd); chk_bank("R7 15-bit frame discarded");
        xfer({15'h0, 16'h8055, 1'b1}, 17, rd); chk_bank("R7 17-bit frame discarded");
        write16(16'h8277);
        chk(cfg[7*16 +: 16] === 16'h8277, "R7 exact frame after discard", 32'(cfg[7*16 +: 16]), 32'h8277);

        // R5/R6 sweep of every top byte
        for (int hi = 0; hi < 256; hi++) begin
            write16({8'(hi), 8'(hi) ^ 8'hA5});
            chk_bank("R5/R6 sweep");
        end

        // R10 / R9 status capture and serial order
        stat = 16'h0000;
        pulse(16'h8020, 16'h0008);
        repeat (4) @(negedge clk);
        chk(sdo === 1'b0, "R9 sdo low with cs high", 32'(sdo), 0);
        xfer(32'h0, 16, rd);
        chk(rd[15:0] === 16'h8028, "R10 status snapshot", rd, 32'h8028);

        // R11 cleared after read, live bit stays
        xfer(32'h0, 16, rd);
        chk(rd[15:0] === 16'h0008, "R11 events cleared by read", rd, 32'h0008);

        // R11 write frame does not clear
        pulse(16'h2000, 16'h0008);
        write16(16'h8011);
        xfer(32'h0, 16, rd);
        chk(rd[15:0] === 16'h2008, "R11 write frame keeps events", rd, 32'h2008);

        // R10 live bit follows input
        stat = 16'h0100;
        repeat (4) @(negedge clk);
        xfer(32'h0, 16, rd);
        chk(rd[15:0] === 16'h0100, "R10 live bit follows", rd, 32'h0100);

        // R12 hardware reset mid-run
        write16(16'hC4AA);
        pulse(16'h4000, 16'h0000);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        model_reset();
        chk_bank("R12 defaults after reset");
        xfer(32'h0, 16, rd);
        chk(rd[15:0] === 16'h0000, "R12 events cleared by reset", rd, 32'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule